// File: doc/BRIEF.md
# Multi-Port Interrupt Aggregator

This block gathers interrupt conditions from several line-interface ports and reduces them to a single registered interrupt line. Each port raises four kinds of aperiodic event: monitor-channel receive, monitor-channel transmit, control/indication receive and control/indication transmit. Each event sets a sticky pending flag. Software clears a flag by reading that port's data register for the matching channel; the clear happens as a side effect of the read. Each port also presents two periodic request levels, one for each B channel.

Masking works at three levels. A per-port on/off bit silences everything from that port. Per-B-channel enables gate only the periodic requests. An interrupt-control register holds a port-wide enable and one enable per aperiodic source. Masking only gates the output: flags keep latching and appear in a read-only summary register. That register shows, for each kind of event, which ports have it pending. The processor side is a plain read/write strobe interface with a combinational read path.

Register address is `{space, port, reg}`. Space 0 is the summary register at any address with the top bit clear. Space 1 selects a port and a 3-bit register index:

| Index | Register |
|---|---|
| 0 | configuration |
| 1 | interrupt control |
| 2 | monitor-receive data |
| 3 | monitor-transmit data |
| 4 | control/indication-receive data |
| 5 | control/indication-transmit data |
| 6, 7 | reserved |

Top module: `port_irq_aggregator`

## Requirements
- R1: After reset, irqOut is 0 and every configuration, interrupt-control and pending flag reads as 0.
- R2: A high on evtIn[p*4+s] sets a sticky flag for port p and source s. Sources are numbered s=0 monitor receive, 1 monitor transmit, 2 control/indication receive, 3 control/indication transmit. The summary register shows that flag at bit s*NUM_PORTS+p, and reading the summary clears nothing.
- R3: A read of port p's data register at index 2+s returns the flag in bit 0 (other bits 0) and clears it on that clock edge.
- R4: When an event and a clearing read for the same flag meet in one cycle, the flag stays set.
- R5: Configuration register fields are bit 0 port on, bit 1 B1 enable and bit 2 B2 enable. With bit 0 clear, the port contributes nothing to irqOut.
- R6: Clearing the B1 (B2) enable masks only that port's b1Req (b2Req) periodic request; aperiodic flags are unaffected.
- R7: Interrupt-control register fields are bit 0 port-wide enable and bits 4:1 per-source enables for sources 0..3. With bit 0 clear, the port contributes nothing; a clear source enable masks only that source.
- R8: Masked flags keep latching and drive irqOut once unmasked.
- R9: irqOut equals, one clock later, the OR over ports of (on AND port-wide enable AND (any enabled pending flag OR any B-enabled periodic request)).
- R10: Writes to the summary register, data registers and reserved indices 6 and 7 change nothing; reserved indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_PORTS*4 | Aperiodic event pulses, bit p*4+s |
| b1Req | input | NUM_PORTS | Periodic B1 request level per port |
| b2Req | input | NUM_PORTS | Periodic B2 request level per port |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (triggers clear-on-read) |
| addr | input | 1+PORT_W+3 | Register address {space, port, index} |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr (combinational) |
| irqOut | output | 1 | Registered aggregate interrupt |

## Verification
The bench builds the block with its default of four ports, giving a two-bit port field and a 16-bit summary register. With that build, every port index is a legal target, and the reserved indices 6 and 7 of each port can be addressed. Random events and register traffic at this size often make clearing reads land in the same cycle as new events on the same flag. They also make mask changes land while flags are pending across several ports at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC    = 4;   // aperiodic sources per port
  localparam int MAX_PORT_W = 4;   // strobe struct carries up to 16 ports
  localparam int REG_IDX_W  = 3;   // register index field width

  // configuration register fields
  localparam int CFG_ON = 0;
  localparam int CFG_B1 = 1;
  localparam int CFG_B2 = 2;
  localparam int CFG_W  = 3;
  // interrupt-control register fields
  localparam int ICR_IE  = 0;
  localparam int ICR_SRC = 1;
  localparam int ICR_W   = 1 + NUM_SRC;

  typedef enum logic [2:0] {RD_NONE, RD_SUM, RD_CFG, RD_ICR, RD_DATA} rdKind_e;

  typedef struct packed {
    logic                  cfgWr;
    logic                  icrWr;
    logic [NUM_SRC-1:0]    clrSrc;
    logic [MAX_PORT_W-1:0] portSel;
    rdKind_e               rdKind;
    logic [1:0]            rdSrc;
  } aggStb_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2,
  parameter int ADDR_W    = 6
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output aggStb_t           stb
);
  logic              isPort;
  logic              portValid;
  logic [PORT_W-1:0] portIdx;
  logic [REG_IDX_W-1:0] regIdx;
  logic [REG_IDX_W-1:0] srcOff;

  always_comb begin
    isPort    = addr[ADDR_W-1];
    portIdx   = addr[REG_IDX_W +: PORT_W];
    regIdx    = addr[REG_IDX_W-1:0];
    portValid = (int'(portIdx) < NUM_PORTS);
    srcOff    = regIdx - REG_IDX_W'(2);

    stb         = '0;
    stb.rdKind  = RD_NONE;
    stb.portSel = MAX_PORT_W'(portIdx);
    stb.rdSrc   = srcOff[1:0];

    if (!isPort) begin
      stb.rdKind = RD_SUM;
    end else if (portValid) begin
      case (regIdx)
        3'd0:                   stb.rdKind = RD_CFG;
        3'd1:                   stb.rdKind = RD_ICR;
        3'd2, 3'd3, 3'd4, 3'd5: stb.rdKind = RD_DATA;
        default:                stb.rdKind = RD_NONE;
      endcase
    end

    stb.cfgWr = wrEn && (stb.rdKind == RD_CFG);
    stb.icrWr = wrEn && (stb.rdKind == RD_ICR);
    for (int s = 0; s < NUM_SRC; s++) begin
      stb.clrSrc[s] = rdEn && (stb.rdKind == RD_DATA) && (stb.rdSrc == 2'(s));
    end
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2,
  parameter int DATA_W    = 16,
  localparam int EVT_W    = NUM_PORTS * NUM_SRC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  aggStb_t              stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [EVT_W-1:0]     evtIn,
  input  logic [NUM_PORTS-1:0] b1Req,
  input  logic [NUM_PORTS-1:0] b2Req,
  output logic [DATA_W-1:0]    rdData,
  output logic [EVT_W-1:0]     flagVec,
  output logic                 irqOut
);
  logic [CFG_W*NUM_PORTS-1:0] cfgFlat;
  logic [ICR_W*NUM_PORTS-1:0] icrFlat;
  logic [NUM_PORTS-1:0]       portIrq;
  logic [EVT_W-1:0]           sumVec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic               sel;
    logic [CFG_W-1:0]   cfgQ;
    logic [ICR_W-1:0]   icrQ;
    logic [NUM_SRC-1:0] flagQ;
    logic [NUM_SRC-1:0] clrHit;
    logic               aperHit;
    logic               perHit;

    assign sel    = (stb.portSel == MAX_PORT_W'(p));
    assign clrHit = stb.clrSrc & {NUM_SRC{sel}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ  <= '0;
        icrQ  <= '0;
        flagQ <= '0;
      end else begin
        if (stb.cfgWr && sel) cfgQ <= wrData[CFG_W-1:0];
        if (stb.icrWr && sel) icrQ <= wrData[ICR_W-1:0];
        // a new event wins over a clearing read in the same cycle
        flagQ <= evtIn[p*NUM_SRC +: NUM_SRC] | (flagQ & ~clrHit);
      end
    end

    assign aperHit = |(flagQ & icrQ[ICR_SRC +: NUM_SRC]);
    assign perHit  = (b1Req[p] && cfgQ[CFG_B1]) || (b2Req[p] && cfgQ[CFG_B2]);
    assign portIrq[p] = cfgQ[CFG_ON] && icrQ[ICR_IE] && (aperHit || perHit);

    assign cfgFlat[p*CFG_W +: CFG_W]       = cfgQ;
    assign icrFlat[p*ICR_W +: ICR_W]       = icrQ;
    assign flagVec[p*NUM_SRC +: NUM_SRC]   = flagQ;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sum
      assign sumVec[s*NUM_PORTS + p] = flagQ[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |portIrq;
  end

  always_comb begin
    int rp;
    rp     = int'(stb.portSel[PORT_W-1:0]);
    rdData = '0;
    case (stb.rdKind)
      RD_SUM:  rdData = DATA_W'(sumVec);
      RD_CFG:  rdData = DATA_W'(cfgFlat[rp*CFG_W +: CFG_W]);
      RD_ICR:  rdData = DATA_W'(icrFlat[rp*ICR_W +: ICR_W]);
      RD_DATA: rdData[0] = flagVec[rp*NUM_SRC + int'(stb.rdSrc)];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/port_irq_aggregator.sv
module port_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int  NUM_PORTS = 4,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W    = 1 + PORT_W + REG_IDX_W,
  localparam int EVT_W     = NUM_PORTS * NUM_SRC,
  localparam int DATA_W    = (EVT_W > 8) ? EVT_W : 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_W-1:0]     evtIn,
  input  logic [NUM_PORTS-1:0] b1Req,
  input  logic [NUM_PORTS-1:0] b2Req,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);
  aggStb_t          stb;
  logic [EVT_W-1:0] flagVec;

  irq_agg_ctrl #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
  ) i_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  irq_agg_dp #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .evtIn(evtIn),
    .b1Req(b1Req), .b2Req(b2Req), .rdData(rdData), .flagVec(flagVec),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int  NUM_PORTS = 4,
  localparam int EVT_W     = NUM_PORTS * NUM_SRC
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [EVT_W-1:0]     evtIn,
  input logic [EVT_W-1:0]     flagVec,
  input aggStb_t              stb,
  input logic [NUM_PORTS-1:0] b1Req,
  input logic [NUM_PORTS-1:0] b2Req,
  input logic                 irqOut
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    logic clrHit;
    assign clrHit = stb.clrSrc[i % NUM_SRC] &&
                    (stb.portSel == MAX_PORT_W'(i / NUM_SRC));

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> flagVec[i]);                                    // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (flagVec[i] && !clrHit) |=> flagVec[i]);                     // R2
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit && !evtIn[i]) |=> !flagVec[i]);                      // R3
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rstN)
      (!flagVec[i] && !evtIn[i]) |=> !flagVec[i]);                 // R2
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!(|flagVec) && !(|b1Req) && !(|b2Req)) |=> !irqOut);          // R9
endmodule

bind port_irq_aggregator irq_agg_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .flagVec(flagVec), .stb(stb),
  .b1Req(b1Req), .b2Req(b2Req), .irqOut(irqOut)
);

// File: tb/test_port_irq_aggregator.sv
`timescale 1ns/1ps
module test_port_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtIn = '0;
  logic [3:0]  b1Req = '0;
  logic [3:0]  b2Req = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]  mCfg [4];
  logic [4:0]  mIcr [4];
  logic [15:0] mFlag;

  always #4 clk = ~clk;

  port_irq_aggregator #(.NUM_PORTS(4)) i_port_irq_aggregator (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .b1Req(b1Req), .b2Req(b2Req),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [5:0] pa(int port, int idx);
    return {1'b1, 2'(port), 3'(idx)};
  endfunction

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int p = 0; p < 4; p++) begin
      logic ap, per;
      ap  = |(mFlag[p*4 +: 4] & mIcr[p][4:1]);
      per = (b1Req[p] & mCfg[p][1]) | (b2Req[p] & mCfg[p][2]);
      r   = r | (mCfg[p][0] & mIcr[p][0] & (ap | per));
    end
    return r;
  endfunction

  function automatic logic [15:0] expRd(logic [5:0] a);
    logic [15:0] v = '0;
    int port = int'(a[4:3]);
    int idx  = int'(a[2:0]);
    if (!a[5]) begin
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) v[s*4 + p] = mFlag[p*4 + s];
    end else if (idx == 0) v = 16'(mCfg[port]);
    else if (idx == 1)     v = 16'(mIcr[port]);
    else if (idx <= 5)     v[0] = mFlag[port*4 + idx - 2];
    return v;
  endfunction

  function automatic string tagFor(logic [5:0] a);
    if (!a[5]) return "R2";
    if (a[2:0] <= 3'd1) return "R5";
    if (a[2:0] <= 3'd5) return "R3";
    return "R10";
  endfunction

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one bus cycle; entered just after a falling edge
  task automatic step(logic [15:0] e, logic wr, logic rd, logic [5:0] a,
                      logic [15:0] d, string tag);
    logic eI;
    logic [15:0] clr = '0;
    evtIn = e; wrEn = wr; rdEn = rd; addr = a; wrData = d;
    #1;
    if (rd) chk(tag, "rdData", rdData, expRd(a));
    eI = expIrq();
    if (rd && a[5] && a[2:0] >= 3'd2 && a[2:0] <= 3'd5)
      clr[int'(a[4:3])*4 + int'(a[2:0]) - 2] = 1'b1;
    mFlag = e | (mFlag & ~clr);
    if (wr && a[5] && a[2:0] == 3'd0) mCfg[int'(a[4:3])] = d[2:0];
    if (wr && a[5] && a[2:0] == 3'd1) mIcr[int'(a[4:3])] = d[4:0];
    @(posedge clk);
    @(negedge clk);
    chk((tag == "R9") ? "R9" : {tag, "/R9"}, "irqOut", 16'(irqOut), 16'(eI));
  endtask

  task automatic idle(string tag);
    step('0, 1'b0, 1'b0, 6'h0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < 4; p++) begin mCfg[p] = '0; mIcr[p] = '0; end
    mFlag = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "irqOut after reset", 16'(irqOut), 16'h0);
    step('0, 0, 1, 6'h00, '0, "R1");
    step('0, 0, 1, pa(0, 0), '0, "R1");
    step('0, 0, 1, pa(3, 1), '0, "R1");

    // R8 masked flag keeps latching, shows after unmask
    step('0, 1, 0, pa(0, 0), 16'h1, "R5");
    step(16'h0001, 0, 0, 6'h0, '0, "R8");
    step('0, 0, 1, 6'h00, '0, "R8");
    step('0, 1, 0, pa(0, 1), 16'h03, "R7");
    idle("R8");
    chk("R8", "irqOut unmasked", 16'(irqOut), 16'h1);
    // R3 clear on read
    step('0, 0, 1, pa(0, 2), '0, "R3");
    idle("R3");
    step('0, 0, 1, pa(0, 2), '0, "R3");

    // R4 event and clear in same cycle
    step(16'h0080, 0, 0, 6'h0, '0, "R4");
    step(16'h0080, 0, 1, pa(1, 5), '0, "R4");
    step('0, 0, 1, 6'h00, '0, "R4");
    step('0, 0, 1, pa(1, 5), '0, "R4");

    // R6 per-B-channel enables
    step('0, 1, 0, pa(2, 0), 16'h3, "R6");
    step('0, 1, 0, pa(2, 1), 16'h1, "R6");
    b2Req = 4'b0100;
    idle("R6"); idle("R6");
    chk("R6", "B2 masked", 16'(irqOut), 16'h0);
    b1Req = 4'b0100;
    idle("R6"); idle("R6");
    chk("R6", "B1 enabled", 16'(irqOut), 16'h1);
    // R7 port-wide enable off
    step('0, 1, 0, pa(2, 1), 16'h1E, "R7");
    idle("R7");
    chk("R7", "port-wide off", 16'(irqOut), 16'h0);
    b1Req = '0; b2Req = '0;

    // R5 port off masks aperiodic
    step(16'h0002, 1, 0, pa(0, 1), 16'h05, "R5");
    idle("R5");
    step('0, 1, 0, pa(0, 0), 16'h0, "R5");
    idle("R5");
    chk("R5", "port off", 16'(irqOut), 16'h0);

    // R10 ignored writes
    step('0, 1, 0, 6'h00, 16'hFFFF, "R10");
    step('0, 1, 0, pa(0, 6), 16'hFFFF, "R10");
    step('0, 1, 0, pa(2, 2), 16'hFFFF, "R10");
    step('0, 0, 1, 6'h00, '0, "R10");
    step('0, 0, 1, pa(0, 6), '0, "R10");
    step('0, 0, 1, pa(2, 2), '0, "R10");
    step('0, 0, 1, pa(0, 0), '0, "R10");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e = '0;
      int op = int'($urandom_range(0, 9));
      logic [5:0] a = 6'($urandom);
      logic [15:0] d = 16'($urandom);
      for (int i = 0; i < 16; i++) e[i] = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 15) == 0) b1Req = 4'($urandom);
      if ($urandom_range(0, 15) == 0) b2Req = 4'($urandom);
      if (op < 4) begin
        step(e, 0, 1, a, '0, tagFor(a));
      end else if (op < 6) begin
        a = pa(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)));
        if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
        step(e, 1, 0, a, d, a[0] ? "R7" : "R5");
      end else if (op == 6) begin
        step(e, 1, 0, a, d, "R10");
      end else begin
        step(e, 0, 0, a, '0, "R9");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule